// File: doc/BRIEF.md
# Token-Counting Coherence Responder

This block is the per-block coherence controller of one node in a system that keeps caches coherent by counting tokens rather than by storing a state field. Each memory block owns a fixed number of tokens, `NUM_TOKENS`. One of them is the distinguished owner token. The node stores three things: how many plain (non-owner) tokens it holds, whether it holds the owner token, and whether its copy of the data is valid. The stable state (I, S, O or M) and the local read and write permissions are all derived from that storage.

Transient requests arrive on the request port as hints. The block answers them from its token holdings. Token messages arrive on the message input and are always absorbed. When the local persistent-request table reports an active request from another node, that request takes priority over every transient answer: the block forwards to the requester all the tokens it holds, and also any tokens that arrive later. An eviction strobe returns all held tokens to the home node. Outgoing messages leave one cycle after the event that caused them. At most one message leaves per cycle.

Top module: `token_responder`

## Requirements
- R1: After reset, the home node (`MY_ID == HOME_ID`) holds all `NUM_TOKENS` tokens with valid data. Any other node holds none. `msgOutValid` is low.
- R2: `blockState` is encoded I=0, S=1, O=2, M=3. It is M when all tokens are held, O when the owner token is held without all the others, S when only plain tokens are held, and I when no tokens are held. `canRead` is high only when at least one token is held and the data is valid. `canWrite` is high only when all tokens are held.
- R3: The data-valid flag is set by an absorbed message that carries data and at least one token. It clears when the node's holding drops to zero. Plain tokens that arrive without data leave it unchanged.
- R4: Every outgoing message that carries the owner token also carries data (`msgOutData` high).
- R5: With no tokens held, transient requests produce no message and leave the state unchanged.
- R6: With only plain tokens held, a shared request (`reqExcl=0`) is ignored. An exclusive request (`reqExcl=1`) sends every held plain token to the requester, without data.
- R7: With the owner token held but not every token, a shared request sends data plus one plain token. If no plain token is held, it sends data plus the owner token, and the node drops to I.
- R8: With the owner token held, an exclusive request sends data plus every held token to the requester.
- R9: In M, a shared request gets data plus all tokens if the block was written locally while all tokens were held (`localWrite`). Otherwise it gets data plus one plain token. A write strobe while not holding all tokens does not mark the block written.
- R10: While `persistActive` is high and `persistDst` differs from `MY_ID`, every held token goes to `persistDst`, with data when the owner token goes. This also applies to tokens absorbed later. Transient requests are not answered in those cycles.
- R11: On `evictReq`, a non-home node sends all held tokens to `HOME_ID`, with data only if the owner token is among them, and drops to I. The home node ignores the strobe.
- R12: Token count is conserved: each cycle, the tokens held equal the previous holding, plus the tokens absorbed, minus the tokens sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Transient request present |
| reqExcl | input | 1 | 1 = exclusive request, 0 = shared request |
| reqSrc | input | NODE_W | Requesting node |
| msgInValid | input | 1 | Incoming token message present |
| msgInCount | input | CNT_W | Plain tokens carried by the incoming message |
| msgInOwner | input | 1 | Incoming message carries the owner token |
| msgInData | input | 1 | Incoming message carries data |
| persistActive | input | 1 | A persistent request is active for this block |
| persistDst | input | NODE_W | Node that issued the active persistent request |
| evictReq | input | 1 | Return all tokens to the home node |
| localWrite | input | 1 | Local processor writes the block |
| msgOutValid | output | 1 | Outgoing message present |
| msgOutDst | output | NODE_W | Destination node |
| msgOutCount | output | CNT_W | Plain tokens carried |
| msgOutOwner | output | 1 | Owner token carried |
| msgOutData | output | 1 | Data carried |
| canRead | output | 1 | Local read permission |
| canWrite | output | 1 | Local write permission |
| blockState | output | 2 | Derived stable state |

## Verification
The bench builds two nodes with four tokens per block. The first is a non-home node with identifier 2, which is driven through every scenario. The second is a home node, which is only observed for its reset holding. Four tokens leave room for a non-owner count to step from two down to zero. That makes it possible to exercise the O-state case where a holder with no plain tokens gives up the owner token, and it also separates the full-handoff answer of the migratory M case from the one-token answer.

// File: rtl/token_responder_pkg.sv
package token_responder_pkg;

  localparam int MaxCntW = 8;
  localparam int MaxIdW  = 8;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_O = 2'd2,
    ST_M = 2'd3
  } blkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               send;
    logic [MaxCntW-1:0] sendCnt;
    logic               sendOwner;
    logic               sendData;
    logic [MaxIdW-1:0]  sendDst;
    logic               markWritten;
  } tokStrobe_t;

endpackage

// File: rtl/token_responder_ctrl.sv
module token_responder_ctrl
  import token_responder_pkg::*;
#(
  parameter int NUM_TOKENS = 4,
  parameter int NODE_W     = 3,
  parameter int MY_ID      = 1,
  parameter int HOME_ID    = 0,
  localparam int CNT_W     = $clog2(NUM_TOKENS),
  localparam int TOT_W     = CNT_W + 1
) (
  input  logic              reqValid,
  input  logic              reqExcl,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic              persistActive,
  input  logic [NODE_W-1:0] persistDst,
  input  logic              evictReq,
  input  logic              localWrite,
  input  logic [CNT_W-1:0]  heldCnt,
  input  logic              heldOwner,
  input  logic              written,
  output tokStrobe_t        stb
);

  localparam logic [TOT_W-1:0] FullTot = TOT_W'(NUM_TOKENS);
  localparam logic [NODE_W-1:0] MyId   = NODE_W'(MY_ID);
  localparam logic [NODE_W-1:0] HomeId = NODE_W'(HOME_ID);
  localparam bit IsHome = (MY_ID == HOME_ID);

  logic [TOT_W-1:0] heldTot;
  logic holdsAny, holdsAll, forwardNow, evictNow, answerNow;

  assign heldTot    = TOT_W'(heldCnt) + TOT_W'(heldOwner);
  assign holdsAny   = (heldTot != '0);
  assign holdsAll   = (heldTot == FullTot);
  assign forwardNow = persistActive && (persistDst != MyId) && holdsAny;
  assign evictNow   = !persistActive && evictReq && !IsHome && holdsAny;
  assign answerNow  = !persistActive && !(evictReq && !IsHome) && reqValid && holdsAny;

  always_comb begin
    stb             = '0;
    stb.markWritten = localWrite && holdsAll;
    if (forwardNow) begin
      stb.send      = 1'b1;
      stb.sendCnt   = MaxCntW'(heldCnt);
      stb.sendOwner = heldOwner;
      stb.sendData  = heldOwner;
      stb.sendDst   = MaxIdW'(persistDst);
    end else if (evictNow) begin
      stb.send      = 1'b1;
      stb.sendCnt   = MaxCntW'(heldCnt);
      stb.sendOwner = heldOwner;
      stb.sendData  = heldOwner;
      stb.sendDst   = MaxIdW'(HomeId);
    end else if (answerNow) begin
      stb.sendDst = MaxIdW'(reqSrc);
      if (!heldOwner) begin
        // plain tokens only: exclusive gets them all without data
        if (reqExcl) begin
          stb.send    = 1'b1;
          stb.sendCnt = MaxCntW'(heldCnt);
        end
      end else if (reqExcl || (holdsAll && written)) begin
        stb.send      = 1'b1;
        stb.sendCnt   = MaxCntW'(heldCnt);
        stb.sendOwner = 1'b1;
        stb.sendData  = 1'b1;
      end else if (heldCnt != '0) begin
        stb.send     = 1'b1;
        stb.sendCnt  = MaxCntW'(1);
        stb.sendData = 1'b1;
      end else begin
        stb.send      = 1'b1;
        stb.sendOwner = 1'b1;
        stb.sendData  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/token_responder_dp.sv
module token_responder_dp
  import token_responder_pkg::*;
#(
  parameter int NUM_TOKENS = 4,
  parameter int NODE_W     = 3,
  parameter int MY_ID      = 1,
  parameter int HOME_ID    = 0,
  localparam int CNT_W     = $clog2(NUM_TOKENS),
  localparam int TOT_W     = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgInValid,
  input  logic [CNT_W-1:0]  msgInCount,
  input  logic              msgInOwner,
  input  logic              msgInData,
  input  tokStrobe_t        stb,
  output logic [CNT_W-1:0]  heldCnt,
  output logic              heldOwner,
  output logic              dataValid,
  output logic              written,
  output logic              msgOutValid,
  output logic [NODE_W-1:0] msgOutDst,
  output logic [CNT_W-1:0]  msgOutCount,
  output logic              msgOutOwner,
  output logic              msgOutData
);

  localparam bit IsHome = (MY_ID == HOME_ID);
  localparam logic [TOT_W-1:0] FullTot = TOT_W'(NUM_TOKENS);

  logic [TOT_W:0]   cntSum;
  logic [CNT_W-1:0] nextCnt, inCnt;
  logic             nextOwner, inOwner, inCarriesTok;
  logic [TOT_W-1:0] nextTot;

  assign inCnt        = msgInValid ? msgInCount : '0;
  assign inOwner      = msgInValid && msgInOwner;
  assign inCarriesTok = (inCnt != '0) || inOwner;
  assign cntSum       = (TOT_W+1)'(heldCnt) + (TOT_W+1)'(inCnt)
                      - (TOT_W+1)'(stb.send ? stb.sendCnt : '0);
  assign nextCnt      = cntSum[CNT_W-1:0];
  assign nextOwner    = (heldOwner || inOwner) && !(stb.send && stb.sendOwner);
  assign nextTot      = TOT_W'(nextCnt) + TOT_W'(nextOwner);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCnt   <= IsHome ? CNT_W'(NUM_TOKENS - 1) : '0;
      heldOwner <= IsHome;
      dataValid <= IsHome;
      written   <= 1'b0;
    end else begin
      heldCnt   <= nextCnt;
      heldOwner <= nextOwner;
      if (nextTot == '0)
        dataValid <= 1'b0;
      else if (msgInValid && msgInData && inCarriesTok)
        dataValid <= 1'b1;
      if (nextTot != FullTot)
        written <= 1'b0;
      else if (stb.markWritten)
        written <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgOutValid <= 1'b0;
      msgOutDst   <= '0;
      msgOutCount <= '0;
      msgOutOwner <= 1'b0;
      msgOutData  <= 1'b0;
    end else begin
      msgOutValid <= stb.send;
      msgOutDst   <= stb.send ? NODE_W'(stb.sendDst) : '0;
      msgOutCount <= stb.send ? CNT_W'(stb.sendCnt) : '0;
      msgOutOwner <= stb.send && stb.sendOwner;
      msgOutData  <= stb.send && stb.sendData;
    end
  end

endmodule

// File: rtl/token_responder.sv
module token_responder
  import token_responder_pkg::*;
#(
  parameter int NUM_TOKENS = 4,
  parameter int NODE_W     = 3,
  parameter int MY_ID      = 1,
  parameter int HOME_ID    = 0,
  localparam int CNT_W     = $clog2(NUM_TOKENS),
  localparam int TOT_W     = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqExcl,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic              msgInValid,
  input  logic [CNT_W-1:0]  msgInCount,
  input  logic              msgInOwner,
  input  logic              msgInData,
  input  logic              persistActive,
  input  logic [NODE_W-1:0] persistDst,
  input  logic              evictReq,
  input  logic              localWrite,
  output logic              msgOutValid,
  output logic [NODE_W-1:0] msgOutDst,
  output logic [CNT_W-1:0]  msgOutCount,
  output logic              msgOutOwner,
  output logic              msgOutData,
  output logic              canRead,
  output logic              canWrite,
  output logic [1:0]        blockState
);

  tokStrobe_t       stb;
  logic [CNT_W-1:0] heldCnt;
  logic             heldOwner, dataValid, written;
  logic [TOT_W-1:0] heldTot;
  blkState_e        stateNow;

  token_responder_ctrl #(
    .NUM_TOKENS(NUM_TOKENS), .NODE_W(NODE_W), .MY_ID(MY_ID), .HOME_ID(HOME_ID)
  ) ctrl_i (
    .reqValid(reqValid), .reqExcl(reqExcl), .reqSrc(reqSrc),
    .persistActive(persistActive), .persistDst(persistDst),
    .evictReq(evictReq), .localWrite(localWrite),
    .heldCnt(heldCnt), .heldOwner(heldOwner), .written(written),
    .stb(stb)
  );

  token_responder_dp #(
    .NUM_TOKENS(NUM_TOKENS), .NODE_W(NODE_W), .MY_ID(MY_ID), .HOME_ID(HOME_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .msgInValid(msgInValid), .msgInCount(msgInCount),
    .msgInOwner(msgInOwner), .msgInData(msgInData),
    .stb(stb),
    .heldCnt(heldCnt), .heldOwner(heldOwner),
    .dataValid(dataValid), .written(written),
    .msgOutValid(msgOutValid), .msgOutDst(msgOutDst),
    .msgOutCount(msgOutCount), .msgOutOwner(msgOutOwner),
    .msgOutData(msgOutData)
  );

  assign heldTot = TOT_W'(heldCnt) + TOT_W'(heldOwner);

  always_comb begin
    if (heldTot == TOT_W'(NUM_TOKENS)) stateNow = ST_M;
    else if (heldOwner)                stateNow = ST_O;
    else if (heldTot != '0)            stateNow = ST_S;
    else                               stateNow = ST_I;
  end

  assign blockState = stateNow;
  assign canRead    = (heldTot != '0) && dataValid;
  assign canWrite   = (heldTot == TOT_W'(NUM_TOKENS));

endmodule

// File: rtl/token_responder_chk.sv
module token_responder_chk #(
  parameter int NUM_TOKENS = 4,
  parameter int NODE_W     = 3,
  parameter int MY_ID      = 1,
  localparam int CNT_W     = $clog2(NUM_TOKENS),
  localparam int TOT_W     = CNT_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              msgInValid,
  input logic [CNT_W-1:0]  msgInCount,
  input logic              msgInOwner,
  input logic              persistActive,
  input logic [NODE_W-1:0] persistDst,
  input logic              msgOutValid,
  input logic [NODE_W-1:0] msgOutDst,
  input logic [CNT_W-1:0]  msgOutCount,
  input logic              msgOutOwner,
  input logic              msgOutData,
  input logic              canWrite,
  input logic [1:0]        blockState,
  input logic [TOT_W-1:0]  heldTot
);

  logic [TOT_W+1:0] inTot, outTot;
  assign inTot  = msgInValid  ? (TOT_W+2)'(msgInCount) + (TOT_W+2)'(msgInOwner) : '0;
  assign outTot = msgOutValid ? (TOT_W+2)'(msgOutCount) + (TOT_W+2)'(msgOutOwner) : '0;

  AST_OWNER_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    msgOutValid && msgOutOwner |-> msgOutData) else $error("owner sent without data"); // R4

  AST_TOKEN_CONSERVED: assert property (@(posedge clk) disable iff (!rstN)
    ((TOT_W+2)'(heldTot) + outTot) == ((TOT_W+2)'($past(heldTot)) + $past(inTot)))
    else $error("token count not conserved"); // R12

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    heldTot <= TOT_W'(NUM_TOKENS)) else $error("holding exceeds total"); // R12

  AST_WRITE_IS_M: assert property (@(posedge clk) disable iff (!rstN)
    canWrite |-> blockState == 2'd3) else $error("write without M"); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    heldTot == '0 && !persistActive && reqValid |=> !msgOutValid)
    else $error("I state answered"); // R5

  AST_PERSIST_FWD: assert property (@(posedge clk) disable iff (!rstN)
    persistActive && persistDst != NODE_W'(MY_ID) && heldTot != '0
    |=> msgOutValid && msgOutDst == $past(persistDst))
    else $error("persistent forward missing"); // R10

endmodule

bind token_responder token_responder_chk #(
  .NUM_TOKENS(NUM_TOKENS), .NODE_W(NODE_W), .MY_ID(MY_ID)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .msgInValid(msgInValid), .msgInCount(msgInCount), .msgInOwner(msgInOwner),
  .persistActive(persistActive), .persistDst(persistDst),
  .msgOutValid(msgOutValid), .msgOutDst(msgOutDst), .msgOutCount(msgOutCount),
  .msgOutOwner(msgOutOwner), .msgOutData(msgOutData),
  .canWrite(canWrite), .blockState(blockState), .heldTot(heldTot)
);

// File: tb/token_responder_tb.sv
module token_responder_tb_top;

  localparam int T  = 4;
  localparam int NW = 3;
  localparam int CW = $clog2(T);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          reqValid = 0, reqExcl = 0;
  logic [NW-1:0] reqSrc = '0;
  logic          msgInValid = 0, msgInOwner = 0, msgInData = 0;
  logic [CW-1:0] msgInCount = '0;
  logic          persistActive = 0;
  logic [NW-1:0] persistDst = '0;
  logic          evictReq = 0, localWrite = 0;

  logic          msgOutValid, msgOutOwner, msgOutData, canRead, canWrite;
  logic [NW-1:0] msgOutDst;
  logic [CW-1:0] msgOutCount;
  logic [1:0]    blockState;

  logic          hOutValid, hOutOwner, hOutData, hCanRead, hCanWrite;
  logic [NW-1:0] hOutDst;
  logic [CW-1:0] hOutCount;
  logic [1:0]    hState;

  token_responder #(.NUM_TOKENS(T), .NODE_W(NW), .MY_ID(2), .HOME_ID(0)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExcl(reqExcl), .reqSrc(reqSrc),
    .msgInValid(msgInValid), .msgInCount(msgInCount), .msgInOwner(msgInOwner),
    .msgInData(msgInData), .persistActive(persistActive), .persistDst(persistDst),
    .evictReq(evictReq), .localWrite(localWrite),
    .msgOutValid(msgOutValid), .msgOutDst(msgOutDst), .msgOutCount(msgOutCount),
    .msgOutOwner(msgOutOwner), .msgOutData(msgOutData),
    .canRead(canRead), .canWrite(canWrite), .blockState(blockState)
  );

  token_responder #(.NUM_TOKENS(T), .NODE_W(NW), .MY_ID(0), .HOME_ID(0)) home_i (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .reqExcl(1'b0), .reqSrc('0),
    .msgInValid(1'b0), .msgInCount('0), .msgInOwner(1'b0), .msgInData(1'b0),
    .persistActive(1'b0), .persistDst('0), .evictReq(1'b0), .localWrite(1'b0),
    .msgOutValid(hOutValid), .msgOutDst(hOutDst), .msgOutCount(hOutCount),
    .msgOutOwner(hOutOwner), .msgOutData(hOutData),
    .canRead(hCanRead), .canWrite(hCanWrite), .blockState(hState)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = 0; reqExcl = 0; reqSrc = '0;
    msgInValid = 0; msgInCount = '0; msgInOwner = 0; msgInData = 0;
    evictReq = 0; localWrite = 0;
  endtask

  // inputs set at negedge; one edge; back at negedge with inputs cleared
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clearIn();
  endtask

  task automatic give(input int cnt, input bit own, input bit dat);
    msgInValid = 1; msgInCount = CW'(cnt); msgInOwner = own; msgInData = dat;
    tick();
  endtask

  task automatic request(input bit excl, input int src);
    reqValid = 1; reqExcl = excl; reqSrc = NW'(src);
    tick();
  endtask

  task automatic expectMsg(input string req, input int dst, input int cnt,
                           input bit own, input bit dat);
    check(req, "msgOutValid", msgOutValid, 1);
    check(req, "msgOutDst", msgOutDst, dst);
    check(req, "msgOutCount", msgOutCount, cnt);
    check(req, "msgOutOwner", msgOutOwner, own);
    check(req, "msgOutData", msgOutData, dat);
  endtask

  task automatic testReset();
    check("R1", "node state", blockState, 0);
    check("R1", "node canRead", canRead, 0);
    check("R1", "node canWrite", canWrite, 0);
    check("R1", "node msgOutValid", msgOutValid, 0);
    check("R1", "home state", hState, 3);
    check("R1", "home canRead", hCanRead, 1);
    check("R1", "home canWrite", hCanWrite, 1);
  endtask

  task automatic testIdleIgnores();
    request(1'b0, 1);
    check("R5", "shared in I out", msgOutValid, 0);
    request(1'b1, 3);
    check("R5", "excl in I out", msgOutValid, 0);
    check("R5", "state", blockState, 0);
  endtask

  task automatic testValidBit();
    give(1, 0, 0);
    check("R3", "state after dataless", blockState, 1);
    check("R3", "canRead without data", canRead, 0);
    give(1, 0, 1);
    check("R3", "canRead with data", canRead, 1);
    check("R2", "canWrite in S", canWrite, 0);
  endtask

  task automatic testSharedHolder();
    request(1'b0, 1);
    check("R6", "shared in S out", msgOutValid, 0);
    check("R6", "state kept", blockState, 1);
    request(1'b1, 3);
    expectMsg("R6", 3, 2, 0, 0);
    check("R6", "state after excl", blockState, 0);
    check("R3", "valid cleared", canRead, 0);
  endtask

  task automatic testOwnerShared();
    give(3, 1, 1);
    check("R2", "state M", blockState, 3);
    check("R2", "canWrite M", canWrite, 1);
    request(1'b0, 1);   // clean M: one token
    expectMsg("R9", 1, 1, 0, 1);
    check("R2", "state O", blockState, 2);
    request(1'b0, 1);
    expectMsg("R7", 1, 1, 0, 1);
    request(1'b0, 4);
    expectMsg("R7", 4, 1, 0, 1);
    check("R7", "still O", blockState, 2);
    request(1'b0, 5);   // no plain token left
    expectMsg("R7", 5, 0, 1, 1);
    check("R7", "drop to I", blockState, 0);
  endtask

  task automatic testMigratory();
    give(3, 1, 1);
    localWrite = 1;
    tick();
    request(1'b0, 6);
    expectMsg("R9", 6, 3, 1, 1);
    check("R9", "state I", blockState, 0);
  endtask

  task automatic testWriteIgnored();
    give(2, 1, 1);      // O with 3 tokens
    localWrite = 1;     // not all tokens: no effect
    tick();
    give(1, 0, 0);      // now M
    check("R9", "M reached", blockState, 3);
    request(1'b0, 1);
    expectMsg("R9", 1, 1, 0, 1);
    request(1'b1, 5);   // O exclusive
    expectMsg("R8", 5, 2, 1, 1);
    check("R8", "state I", blockState, 0);
  endtask

  task automatic testPersist();
    give(3, 1, 1);
    persistActive = 1; persistDst = NW'(6);
    reqValid = 1; reqExcl = 0; reqSrc = NW'(1);
    tick();
    expectMsg("R10", 6, 3, 1, 1);
    check("R10", "state I", blockState, 0);
    give(1, 0, 0);      // arrives later, absorbed this edge
    check("R10", "nothing yet", msgOutValid, 0);
    tick();
    expectMsg("R10", 6, 1, 0, 0);
    persistDst = NW'(2);  // own persistent request: keep tokens
    give(2, 0, 1);
    tick();
    check("R10", "own request keeps", msgOutValid, 0);
    check("R10", "own request state", blockState, 1);
    persistActive = 0;
  endtask

  task automatic testEvict();
    evictReq = 1;       // holding 2 plain tokens
    tick();
    expectMsg("R11", 0, 2, 0, 0);
    check("R11", "state I", blockState, 0);
    give(1, 1, 1);
    evictReq = 1;
    tick();
    expectMsg("R11", 0, 1, 1, 1);
    check("R11", "home unaffected", hState, 3);
  endtask

  initial begin
    fork
      begin
        clearIn();
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1;
        @(negedge clk);
        testIdleIgnores();
        testValidBit();
        testSharedHolder();
        testOwnerShared();
        testMigratory();
        testWriteIgnored();
        testPersist();
        testEvict();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule